// File: doc/BRIEF.md
# Segment descriptor cache unit

This unit keeps the hidden per-segment state that address generation uses: a 32-bit base, a 32-bit byte limit and a set of access-right bits for each of six segment registers. Each accepted load request updates one segment. In real mode the request carries only the 16-bit selector. In protected mode it also carries the 64-bit descriptor that an outside fetcher has already read from the descriptor table. The unit unpacks that descriptor, checks it against the destination register and either commits it or reports a protection fault.

A real-mode load replaces only the base. Limit and rights set earlier by a protected-mode load therefore stay in force, so a 4 GB limit remains usable after a return to real mode. The parameter `LEGACY_CS` selects an older code-segment behaviour in which every real-mode CS load restores fixed real-mode values.

Three other paths use the cached state. A read port returns the cached fields of one segment. An access port adds an offset to a segment base and flags offsets beyond the limit. A debug port writes any single cached field directly. The current privilege level comes from the cached stack segment.

Top module: `segcache_unit`

## Requirements
- R1: After reset every segment holds base 0, limit 0x0000FFFF and rights 0x093, and `cpl` is 0.
- R2: In real mode (`ld_prot`=0) a load sets the target base to the selector value times 16.
- R3: A real-mode load of SS, DS, ES, FS or GS leaves that segment's limit and rights unchanged, including a 4 GB limit from an earlier protected load.
- R4: With `LEGACY_CS`=0 a real-mode CS load (index 0) keeps the CS limit and rights. With `LEGACY_CS`=1 it sets the CS rights to 0x093 and the CS limit to 0x0000FFFF.
- R5: A passing protected load caches base = {d[63:56], d[39:16]} and rights = {G d[55], D/B d[54], AVL d[52], P d[47], DPL d[46:45], S d[44], type d[43:40]}, with bit 10 down to bit 0 in that order.
- R6: The 20-bit raw limit is {d[51:48], d[15:0]}. It is cached as is when G=0 and as (raw << 12) | 0xFFF when G=1.
- R7: A protected load faults with code 1 and leaves the cache unchanged in any of these cases: S=0; CS with type bit 3 (executable) clear; any other segment with type bit 3 set.
- R8: A protected load of a descriptor that passes R7 but has P=0 faults with code 2 and leaves the cache unchanged.
- R9: A protected load whose selector bits 15:2 are all zero is a null load. For SS it faults with code 3, and for CS with code 1. For DS, ES, FS or GS it raises no fault and sets base, limit and rights to 0. The null check comes before every other check.
- R10: `cpl` equals the DPL bits (rights bits 6:5) of the cached SS entry (index 1).
- R11: `acc_lin` = base + `acc_off` of segment `acc_seg`. `acc_viol` is high exactly when `acc_off` > that segment's limit.
- R12: A debug write (`dbg_field` 0 = base, 1 = limit, 2 = rights from `dbg_data[10:0]`) changes one field on the next edge, and the value stays until that segment is loaded again. In the same cycle, a load to the same segment takes priority over the debug write.
- R13: `ld_ready` is always high. Each accepted load with index below 6 pulses `ld_done` one cycle later, together with `flt_valid`/`flt_code`. A load with index 6 or 7 is ignored: no pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request ready (always high) |
| ld_seg | input | 3 | Target segment: 0 CS, 1 SS, 2 DS, 3 ES, 4 FS, 5 GS |
| ld_prot | input | 1 | 1 = protected-mode load, 0 = real mode |
| ld_sel | input | 16 | Selector value |
| ld_desc | input | 64 | Fetched descriptor (protected mode only) |
| ld_done | output | 1 | One-cycle pulse: a load has completed |
| flt_valid | output | 1 | Completed load faulted |
| flt_code | output | 2 | 0 none, 1 general protection, 2 not present, 3 stack |
| dbg_we | input | 1 | Debug field write strobe |
| dbg_seg | input | 3 | Debug target segment |
| dbg_field | input | 2 | 0 base, 1 limit, 2 rights |
| dbg_data | input | 32 | Debug write value |
| rd_seg | input | 3 | Read port segment select |
| rd_base | output | 32 | Cached base of `rd_seg` |
| rd_limit | output | 32 | Cached limit of `rd_seg` |
| rd_rights | output | 11 | Cached rights of `rd_seg` |
| cpl | output | 2 | Current privilege level |
| acc_seg | input | 3 | Access check segment |
| acc_off | input | 32 | Access offset |
| acc_lin | output | 32 | Linear address |
| acc_viol | output | 1 | Limit violation |

## Verification
The bench builds two copies with six segments: one with `LEGACY_CS`=0, the other with `LEGACY_CS`=1. Both receive the same stimulus, so a single real-mode CS load shows the rights and limit being kept in one copy and forced in the other. The default six-segment size leaves indices 6 and 7 unused, which makes the ignore path of R13 reachable.

// File: rtl/segc_pkg.sv
package segc_pkg;
  localparam int SEG_IDX_W = 3;
  localparam int ADR_W     = 32;

  typedef enum logic [SEG_IDX_W-1:0] {
    SEG_CS = 3'd0, SEG_SS = 3'd1, SEG_DS = 3'd2,
    SEG_ES = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
  } seg_id_e;

  typedef struct packed {
    logic       g;
    logic       db;
    logic       avl;
    logic       p;
    logic [1:0] dpl;
    logic       s;
    logic [3:0] typ;
  } seg_rights_t;

  typedef struct packed {
    logic [ADR_W-1:0] base;
    logic [ADR_W-1:0] limit;
    seg_rights_t      rights;
  } seg_entry_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_GP = 2'd1, FLT_NP = 2'd2, FLT_STK = 2'd3
  } seg_fault_e;

  localparam seg_rights_t RM_RIGHTS = 11'h093;
  localparam logic [ADR_W-1:0] RM_LIMIT = 32'h0000_FFFF;
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import segc_pkg::*;
(
  input  logic [63:0]          desc,
  input  logic [15:0]          sel,
  input  logic [SEG_IDX_W-1:0] seg,
  output seg_entry_t           ent,
  output seg_fault_e           fault
);
  logic [19:0] raw_lim;
  logic        is_cs, is_ss, is_null;

  assign raw_lim = {desc[51:48], desc[15:0]};
  assign is_cs   = (seg == SEG_CS);
  assign is_ss   = (seg == SEG_SS);
  assign is_null = (sel[15:2] == 14'd0);

  always_comb begin
    ent = '0;
    if (!is_null) begin
      ent.base         = {desc[63:56], desc[39:16]};
      ent.limit        = desc[55] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
      ent.rights.g     = desc[55];
      ent.rights.db    = desc[54];
      ent.rights.avl   = desc[52];
      ent.rights.p     = desc[47];
      ent.rights.dpl   = desc[46:45];
      ent.rights.s     = desc[44];
      ent.rights.typ   = desc[43:40];
    end
  end

  always_comb begin
    fault = FLT_NONE;
    if (is_null) begin
      if (is_ss)      fault = FLT_STK;
      else if (is_cs) fault = FLT_GP;
    end else if (!desc[44]) begin
      fault = FLT_GP;
    end else if (is_cs != desc[43]) begin
      fault = FLT_GP;
    end else if (!desc[47]) begin
      fault = FLT_NP;
    end
  end
endmodule

// File: rtl/seg_entry_reg.sv
module seg_entry_reg
  import segc_pkg::*;
#(
  parameter bit IS_CS     = 1'b0,
  parameter bit LEGACY_CS = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_hit,
  input  logic        ld_prot,
  input  logic [15:0] ld_sel,
  input  seg_entry_t  dec_ent,
  input  seg_fault_e  dec_fault,
  input  logic        dbg_hit,
  input  logic [1:0]  dbg_field,
  input  logic [31:0] dbg_data,
  output seg_entry_t  ent_q
);
  localparam bit FORCE_RM = IS_CS && LEGACY_CS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q.base   <= '0;
      ent_q.limit  <= RM_LIMIT;
      ent_q.rights <= RM_RIGHTS;
    end else if (ld_hit) begin
      if (ld_prot) begin
        if (dec_fault == FLT_NONE) ent_q <= dec_ent;
      end else begin
        ent_q.base <= {12'h000, ld_sel, 4'h0};
        if (FORCE_RM) begin
          ent_q.limit  <= RM_LIMIT;
          ent_q.rights <= RM_RIGHTS;
        end
      end
    end else if (dbg_hit) begin
      case (dbg_field)
        2'd0:    ent_q.base   <= dbg_data;
        2'd1:    ent_q.limit  <= dbg_data;
        2'd2:    ent_q.rights <= dbg_data[10:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seg_access_calc.sv
module seg_access_calc
  import segc_pkg::*;
(
  input  seg_entry_t       ent,
  input  logic [ADR_W-1:0] off,
  output logic [ADR_W-1:0] lin,
  output logic             viol
);
  assign lin  = ent.base + off;
  assign viol = (off > ent.limit);
endmodule

// File: rtl/segcache_unit.sv
module segcache_unit
  import segc_pkg::*;
#(
  parameter int NSEG      = 6,
  parameter bit LEGACY_CS = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  output logic        ld_ready,
  input  logic [2:0]  ld_seg,
  input  logic        ld_prot,
  input  logic [15:0] ld_sel,
  input  logic [63:0] ld_desc,
  output logic        ld_done,
  output logic        flt_valid,
  output logic [1:0]  flt_code,
  input  logic        dbg_we,
  input  logic [2:0]  dbg_seg,
  input  logic [1:0]  dbg_field,
  input  logic [31:0] dbg_data,
  input  logic [2:0]  rd_seg,
  output logic [31:0] rd_base,
  output logic [31:0] rd_limit,
  output logic [10:0] rd_rights,
  output logic [1:0]  cpl,
  input  logic [2:0]  acc_seg,
  input  logic [31:0] acc_off,
  output logic [31:0] acc_lin,
  output logic        acc_viol
);
  localparam logic [SEG_IDX_W-1:0] NSEG_L = SEG_IDX_W'(NSEG);

  seg_entry_t ent_q [NSEG];
  seg_entry_t dec_ent, rd_ent, acc_ent;
  seg_fault_e dec_fault;
  logic       ld_in_range;

  assign ld_ready    = 1'b1;
  assign ld_in_range = (ld_seg < NSEG_L);

  seg_desc_decode u_dec (
    .desc (ld_desc),
    .sel  (ld_sel),
    .seg  (ld_seg),
    .ent  (dec_ent),
    .fault(dec_fault)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    seg_entry_reg #(
      .IS_CS    (i == 0),
      .LEGACY_CS(LEGACY_CS)
    ) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_hit   (ld_valid && (ld_seg == SEG_IDX_W'(i))),
      .ld_prot  (ld_prot),
      .ld_sel   (ld_sel),
      .dec_ent  (dec_ent),
      .dec_fault(dec_fault),
      .dbg_hit  (dbg_we && (dbg_seg == SEG_IDX_W'(i))),
      .dbg_field(dbg_field),
      .dbg_data (dbg_data),
      .ent_q    (ent_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_done   <= 1'b0;
      flt_valid <= 1'b0;
      flt_code  <= FLT_NONE;
    end else begin
      ld_done   <= ld_valid && ld_in_range;
      flt_valid <= ld_valid && ld_in_range && ld_prot && (dec_fault != FLT_NONE);
      flt_code  <= (ld_valid && ld_in_range && ld_prot) ? dec_fault : FLT_NONE;
    end
  end

  always_comb begin
    rd_ent  = '0;
    acc_ent = '0;
    if (rd_seg < NSEG_L)  rd_ent  = ent_q[rd_seg];
    if (acc_seg < NSEG_L) acc_ent = ent_q[acc_seg];
  end

  assign rd_base   = rd_ent.base;
  assign rd_limit  = rd_ent.limit;
  assign rd_rights = rd_ent.rights;
  assign cpl       = ent_q[SEG_SS].rights.dpl;

  seg_access_calc u_acc (
    .ent (acc_ent),
    .off (acc_off),
    .lin (acc_lin),
    .viol(acc_viol)
  );
endmodule

// File: rtl/segcache_unit_chk.sv
module segcache_unit_chk
  import segc_pkg::*;
#(
  parameter int NSEG = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_valid,
  input logic [2:0]  ld_seg,
  input logic        ld_prot,
  input logic [15:0] ld_sel,
  input logic        dbg_we,
  input logic        ld_done,
  input logic        flt_valid,
  input logic [1:0]  flt_code,
  input logic [1:0]  cpl,
  input seg_entry_t  ent [NSEG]
);
  localparam int EW = $bits(seg_entry_t);
  logic [NSEG*EW-1:0] flat;

  always_comb begin
    for (int i = 0; i < NSEG; i++) flat[i*EW +: EW] = ent[i];
  end

  // R7, R8: a faulting load changes no cached state
  a_r7_fault_keeps_cache: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && $past(rst_n) && !$past(dbg_we)) |-> (flat == $past(flat)));

  // R2: real-mode base is selector times 16
  a_r2_real_base: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && ld_valid && !ld_prot && ld_seg == SEG_DS)
      |-> (ent[2].base == {12'h000, $past(ld_sel), 4'h0}));

  // R3: real-mode data load keeps limit and rights
  a_r3_real_keeps_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && ld_valid && !ld_prot && ld_seg == SEG_DS && !dbg_we)
      |-> (ent[2].limit == $past(ent[2].limit) && ent[2].rights == $past(ent[2].rights)));

  // R10: real-mode SS load leaves the privilege level alone
  a_r10_cpl_real_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && ld_valid && !ld_prot && ld_seg == SEG_SS && !dbg_we) |-> $stable(cpl));

  // R13: a fault report comes with a completion pulse and a nonzero code
  a_r13_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (ld_done && flt_code != 2'd0));

  // R13: completion only follows an accepted request
  a_r13_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && $past(rst_n)) |-> $past(ld_valid));
endmodule

bind segcache_unit segcache_unit_chk #(.NSEG(NSEG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_valid (ld_valid),
  .ld_seg   (ld_seg),
  .ld_prot  (ld_prot),
  .ld_sel   (ld_sel),
  .dbg_we   (dbg_we),
  .ld_done  (ld_done),
  .flt_valid(flt_valid),
  .flt_code (flt_code),
  .cpl      (cpl),
  .ent      (ent_q)
);

// File: tb/segcache_unit_tb.sv
`timescale 1ns/1ps
module segcache_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ld_valid = 0, ld_prot = 0, dbg_we = 0;
  logic [2:0]  ld_seg = 0, dbg_seg = 0, rd_seg = 0, acc_seg = 0;
  logic [15:0] ld_sel = 0;
  logic [63:0] ld_desc = 0;
  logic [1:0]  dbg_field = 0;
  logic [31:0] dbg_data = 0, acc_off = 0;

  logic        ld_ready, ld_done, flt_valid, acc_viol;
  logic [1:0]  flt_code, cpl;
  logic [31:0] rd_base, rd_limit, acc_lin;
  logic [10:0] rd_rights;

  logic        l_ready, l_done, l_fv, l_viol;
  logic [1:0]  l_fc, l_cpl;
  logic [31:0] l_base, l_limit, l_lin;
  logic [10:0] l_rights;

  segcache_unit #(.NSEG(6), .LEGACY_CS(1'b0)) u_dut (
    .clk, .rst_n, .ld_valid, .ld_ready, .ld_seg, .ld_prot, .ld_sel, .ld_desc,
    .ld_done, .flt_valid, .flt_code, .dbg_we, .dbg_seg, .dbg_field, .dbg_data,
    .rd_seg, .rd_base, .rd_limit, .rd_rights, .cpl, .acc_seg, .acc_off,
    .acc_lin, .acc_viol);

  segcache_unit #(.NSEG(6), .LEGACY_CS(1'b1)) u_dut_leg (
    .clk, .rst_n, .ld_valid, .ld_ready(l_ready), .ld_seg, .ld_prot, .ld_sel,
    .ld_desc, .ld_done(l_done), .flt_valid(l_fv), .flt_code(l_fc), .dbg_we,
    .dbg_seg, .dbg_field, .dbg_data, .rd_seg, .rd_base(l_base),
    .rd_limit(l_limit), .rd_rights(l_rights), .cpl(l_cpl), .acc_seg, .acc_off,
    .acc_lin(l_lin), .acc_viol(l_viol));

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [31:0] m_base [6];
  logic [31:0] m_limit [6];
  logic [10:0] m_rights [6];
  logic [1:0]  expq [$];

  task automatic ck(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] t, input bit s, input logic [1:0] dpl, input bit p,
      input bit g, input bit db);
    return {b[31:24], g, db, 1'b0, 1'b0, l[19:16], p, dpl, s, t, b[23:0], l[15:0]};
  endfunction

  function automatic logic [1:0] exp_flt(input int seg, input bit prot,
      input logic [15:0] sel, input logic [63:0] d);
    if (!prot) return 2'd0;
    if (sel[15:2] == 0) return (seg == 1) ? 2'd3 : (seg == 0) ? 2'd1 : 2'd0;
    if (!d[44]) return 2'd1;
    if ((seg == 0) != d[43]) return 2'd1;
    if (!d[47]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic model_load(input int seg, input bit prot, input logic [15:0] sel, input logic [63:0] d);
    logic [1:0] ef;
    logic [19:0] rl;
    ef = exp_flt(seg, prot, sel, d);
    expq.push_back(ef);
    if (!prot) m_base[seg] = {12'h0, sel, 4'h0};
    else if (ef == 0) begin
      if (sel[15:2] == 0) begin
        m_base[seg] = 0; m_limit[seg] = 0; m_rights[seg] = 0;
      end else begin
        rl = {d[51:48], d[15:0]};
        m_base[seg]   = {d[63:56], d[39:16]};
        m_limit[seg]  = d[55] ? {rl, 12'hFFF} : {12'h0, rl};
        m_rights[seg] = {d[55], d[54], d[52], d[47], d[46:45], d[44], d[43:40]};
      end
    end
  endtask

  task automatic do_load(input int seg, input bit prot, input logic [15:0] sel, input logic [63:0] d);
    @(negedge clk);
    ld_valid = 1; ld_seg = 3'(seg); ld_prot = prot; ld_sel = sel; ld_desc = d;
    if (seg < 6) model_load(seg, prot, sel, d);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic dbg_w(input int seg, input logic [1:0] f, input logic [31:0] v);
    @(negedge clk);
    dbg_we = 1; dbg_seg = 3'(seg); dbg_field = f; dbg_data = v;
    if (f == 0) m_base[seg] = v; else if (f == 1) m_limit[seg] = v; else m_rights[seg] = v[10:0];
    @(negedge clk);
    dbg_we = 0;
  endtask

  task automatic chk_seg(input int seg, input string tag);
    rd_seg = 3'(seg);
    #1;
    ck(rd_base == m_base[seg], {tag, " base"}, rd_base, m_base[seg]);
    ck(rd_limit == m_limit[seg], {tag, " limit"}, rd_limit, m_limit[seg]);
    ck(rd_rights == m_rights[seg], {tag, " rights"}, rd_rights, m_rights[seg]);
  endtask

  // monitor: scoreboard of load completions
  always @(negedge clk) begin
    if (rst_n && ld_done) begin
      if (expq.size() == 0) ck(1'b0, "R13 unexpected ld_done", 1, 0);
      else begin
        logic [1:0] e;
        e = expq.pop_front();
        ck(flt_code == e, "R7/R8/R9 flt_code", flt_code, e);
        ck(flt_valid == (e != 0), "R13 flt_valid", flt_valid, e != 0);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_base[i] = 0; m_limit[i] = 32'hFFFF; m_rights[i] = 11'h093;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset defaults
    for (int i = 0; i < 6; i++) chk_seg(i, "R1 reset");
    ck(cpl == 0, "R1 cpl", cpl, 0);
    ck(ld_ready == 1, "R13 ld_ready", ld_ready, 1);

    // R5, R6: protected DS load with G=1, ES with G=0
    do_load(2, 1, 16'h0010, mk(32'h1234_5678, 20'hFFFFF, 4'h3, 1, 2'd0, 1, 1, 1));
    chk_seg(2, "R5 R6 DS g1");
    do_load(3, 1, 16'h0018, mk(32'hA000_0100, 20'h54321, 4'h2, 1, 2'd2, 1, 0, 0));
    chk_seg(3, "R5 R6 ES g0");

    // R2, R3: real-mode DS load keeps the 4 GB limit
    do_load(2, 0, 16'h1234, 64'h0);
    chk_seg(2, "R2 R3 DS real");
    ck(rd_limit == 32'hFFFF_FFFF, "R3 unreal limit", rd_limit, 32'hFFFF_FFFF);

    // R11 access path
    acc_seg = 3'd2; acc_off = 32'h0010_0000; #1;
    ck(acc_lin == 32'h0011_2340, "R11 lin DS", acc_lin, 32'h0011_2340);
    ck(acc_viol == 0, "R11 no viol DS", acc_viol, 0);
    acc_seg = 3'd3; acc_off = 32'h0005_4322; #1;
    ck(acc_viol == 1, "R11 viol ES", acc_viol, 1);
    acc_off = 32'h0005_4321; #1;
    ck(acc_viol == 0, "R11 edge ES", acc_viol, 0);
    ck(acc_lin == 32'hA005_4421, "R11 lin ES", acc_lin, 32'hA005_4421);

    // R7 type checks
    do_load(0, 1, 16'h0020, mk(32'h0, 20'hFFFF, 4'h3, 1, 2'd0, 1, 0, 0));
    chk_seg(0, "R7 CS data desc");
    do_load(4, 1, 16'h0028, mk(32'h5000, 20'hFF, 4'hA, 1, 2'd0, 1, 0, 0));
    chk_seg(4, "R7 FS code desc");
    do_load(5, 1, 16'h0030, mk(32'h5000, 20'hFF, 4'h2, 0, 2'd0, 1, 0, 0));
    chk_seg(5, "R7 GS system desc");

    // R8 not present
    do_load(3, 1, 16'h0038, mk(32'h7777_0000, 20'h10, 4'h2, 1, 2'd0, 0, 0, 0));
    chk_seg(3, "R8 ES not present");

    // R9 null selectors
    do_load(1, 1, 16'h0003, 64'h0);
    chk_seg(1, "R9 SS null");
    do_load(0, 1, 16'h0000, 64'h0);
    chk_seg(0, "R9 CS null");
    do_load(4, 1, 16'h0002, mk(32'h1, 20'h1, 4'h2, 1, 2'd0, 1, 0, 0));
    chk_seg(4, "R9 FS null ok");

    // R10 CPL from SS
    do_load(1, 1, 16'h0043, mk(32'h0020_0000, 20'hFFFF, 4'h2, 1, 2'd3, 1, 0, 1));
    chk_seg(1, "R10 SS prot");
    ck(cpl == 2'd3, "R10 cpl", cpl, 3);
    do_load(1, 0, 16'h0400, 64'h0);
    ck(cpl == 2'd3, "R10 cpl after real SS", cpl, 3);

    // R4 code segment in real mode, both variants
    do_load(0, 1, 16'h0008, mk(32'h0, 20'h00FFF, 4'hB, 1, 2'd0, 1, 1, 1));
    chk_seg(0, "R5 CS prot");
    do_load(0, 0, 16'hF000, 64'h0);
    chk_seg(0, "R4 CS real LEGACY_CS=0");
    rd_seg = 3'd0; #1;
    ck(l_base == 32'h000F_0000, "R4 legacy CS base", l_base, 32'h000F_0000);
    ck(l_limit == 32'h0000_FFFF, "R4 legacy CS limit", l_limit, 32'hFFFF);
    ck(l_rights == 11'h093, "R4 legacy CS rights", l_rights, 11'h093);

    // R12 debug writes
    dbg_w(2, 2'd1, 32'h0000_0ABC);
    chk_seg(2, "R12 dbg limit");
    acc_seg = 3'd2; acc_off = 32'h0000_0ABD; #1;
    ck(acc_viol == 1, "R12 dbg limit in access", acc_viol, 1);
    dbg_w(5, 2'd0, 32'h0020_0000);
    dbg_w(5, 2'd2, 32'h0000_009B);
    repeat (3) @(negedge clk);
    chk_seg(5, "R12 dbg persists");
    do_load(5, 0, 16'h0100, 64'h0);
    chk_seg(5, "R12 reload replaces base");
    @(negedge clk);
    ld_valid = 1; ld_seg = 3'd2; ld_prot = 0; ld_sel = 16'h0050;
    dbg_we = 1; dbg_seg = 3'd2; dbg_field = 2'd0; dbg_data = 32'hDEAD_0000;
    model_load(2, 0, 16'h0050, 64'h0);
    @(negedge clk);
    ld_valid = 0; dbg_we = 0;
    chk_seg(2, "R12 load beats dbg");

    // R13 out-of-range index ignored
    do_load(6, 1, 16'h0008, mk(32'h0, 20'hFFFF, 4'h2, 1, 2'd0, 1, 0, 0));
    ck(ld_done == 0, "R13 index 6 no done", ld_done, 0);
    for (int i = 0; i < 6; i++) chk_seg(i, "R13 index 6 no change");

    repeat (2) @(negedge clk);
    ck(expq.size() == 0, "R13 all loads completed", expq.size(), 0);
    finish_run();
  end
endmodule